// File: doc/BRIEF.md
# Entropy Seed CSR Access Unit

This block sits next to a RISC-V core's CSR file and answers accesses to the entropy-source CSR at address 0x015. It looks at the decoded CSR instruction fields: funct3, the CSR address, the rs1 index (or the 5-bit immediate, which uses the same field), and the rs1 data. From these it decides whether the access is legal. The decision uses only whether the instruction writes at all, and never the kind of CSR operation. A set or clear form whose rs1 index or immediate is zero is read-only, so it raises an illegal-instruction flag. Every other CSR form is legal. A legal access writes a status-tagged word to rd, and the write operand is discarded.

Fresh 16-bit samples come in on a valid/ready port and are held in a one-entry buffer. The returned word carries a two-bit status. It reads self-test for a fixed number of cycles after reset. After that it reads wait while the buffer is empty, and sample-ready while a sample is held. A latched fault input makes it read dead. A legal read in the sample-ready state empties the buffer. The decision and the returned word are combinational in the access cycle. Buffer and status changes take effect at the following clock edge.

Top module: `seed_csr_unit`

## Requirements
- R1: The block answers only when `csrAddr` equals 0x015. For any other address, `hit`, `rdWe` and `illegal` stay low and no block state changes.
- R2: CSRRW (funct3 001) and CSRRWI (funct3 101) are always legal, for any rs1 index or immediate value, including zero.
- R3: CSRRS (funct3 010) and CSRRC (funct3 011) with `rs1Idx` equal to 0 assert `illegal` and keep `rdWe` low.
- R4: CSRRSI (funct3 110) and CSRRCI (funct3 111) with a zero immediate assert `illegal` and keep `rdWe` low.
- R5: The set and clear forms, both register and immediate, are legal when the rs1 index or immediate is nonzero. This holds even when `rs1Data` is zero, because read-only detection uses only the index field.
- R6: The value on `rs1Data` never affects the returned word or the block state.
- R7: funct3 values 000 and 100 are not CSR accesses and produce no response.
- R8: `rdData[31:30]` carries the status: 00 self-test, 01 wait, 10 sample-ready, 11 dead. `rdData[15:0]` holds the sample only when the status is sample-ready. All other bits are zero.
- R9: A legal read in the sample-ready state empties the buffer. Later reads return wait until a new sample is accepted from the entropy port.
- R10: An illegal access does not empty the buffer, and `rdWe` is low in that cycle.
- R11: For `BIST_CYCLES` clock cycles after reset the status is self-test and `entReady` is low. After that, `entReady` is high exactly while the status is wait.
- R12: A high `faultIn` sampled at a clock edge makes the status dead from the next cycle until reset, and `entReady` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | A decoded CSR instruction is present this cycle |
| funct3 | input | 3 | CSR operation field of the instruction |
| csrAddr | input | 12 | CSR address field |
| rs1Idx | input | 5 | rs1 register index or 5-bit immediate |
| rs1Data | input | 32 | rs1 register value (write operand, ignored) |
| entValid | input | 1 | Entropy port offers a sample |
| entData | input | 16 | Offered entropy sample |
| entReady | output | 1 | Block accepts the offered sample at the clock edge |
| faultIn | input | 1 | Entropy health fault, latched until reset |
| hit | output | 1 | Access addresses this CSR with a CSR funct3 |
| illegal | output | 1 | Access is a read-only form and must trap |
| rdWe | output | 1 | Legal access: write `rdData` to rd |
| rdData | output | 32 | Status-tagged result word |

## Verification
The bench attacks the legality split from every side. It sends zero-index set and clear forms, which a decoder keyed on the operation would let through. It sends nonzero set and clear forms with zero rs1 data, which a decoder that checks the register value would wrongly trap. It sends zero-operand swap forms, which an over-strict decoder would reject. Illegal, off-address and non-CSR accesses are placed between loading a sample and reading it back. A design that consumed on those accesses would return wait instead of the held sample. Back-to-back legal reads check consume-on-read, and a fault pulse followed by a later read checks that the dead state does not decay.

// File: rtl/seed_csr_pkg.sv
package seed_csr_pkg;

  typedef enum logic [1:0] {
    ST_BIST  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_READY = 2'b10,
    ST_DEAD  = 2'b11
  } seedStatus_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic load;
    logic consume;
  } seedStrobe_t;

  localparam logic [11:0] SEED_CSR_ADDR = 12'h015;

endpackage

// File: rtl/seed_csr_ctrl.sv
module seed_csr_ctrl
  import seed_csr_pkg::*;
#(
  parameter int BIST_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic [2:0]  funct3,
  input  logic [11:0] csrAddr,
  input  logic [4:0]  rs1Idx,
  input  logic        bufFull,
  input  logic        entValid,
  input  logic        faultIn,
  output logic        entReady,
  output logic        hit,
  output logic        illegal,
  output logic        rdWe,
  output seedStatus_e status,
  output seedStrobe_t strobe
);

  localparam int CNT_W = $clog2(BIST_CYCLES + 1);
  localparam logic [CNT_W-1:0] BIST_LAST = CNT_W'(BIST_CYCLES);

  logic [CNT_W-1:0] bistCnt;
  logic bistDone;
  logic faultSeen;
  logic isCsrOp;
  logic readOnly;

  assign bistDone = (bistCnt == BIST_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bistCnt   <= '0;
      faultSeen <= 1'b0;
    end else begin
      if (!bistDone) bistCnt <= bistCnt + 1'b1;
      if (faultIn)   faultSeen <= 1'b1;
    end
  end

  // funct3 x00 is not a CSR access; bit 1 marks the set/clear forms
  assign isCsrOp  = (funct3[1:0] != 2'b00);
  assign readOnly = funct3[1] && (rs1Idx == 5'd0);

  assign hit     = accValid && isCsrOp && (csrAddr == SEED_CSR_ADDR);
  assign illegal = hit && readOnly;
  assign rdWe    = hit && !readOnly;

  always_comb begin
    if (faultSeen)      status = ST_DEAD;
    else if (!bistDone) status = ST_BIST;
    else if (bufFull)   status = ST_READY;
    else                status = ST_WAIT;
  end

  assign entReady       = (status == ST_WAIT);
  assign strobe.load    = entReady && entValid;
  assign strobe.consume = rdWe && (status == ST_READY);

endmodule

// File: rtl/seed_csr_dp.sv
module seed_csr_dp
  import seed_csr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  seedStrobe_t         strobe,
  input  seedStatus_e         status,
  input  logic [SAMPLE_W-1:0] entData,
  output logic                bufFull,
  output logic [WORD_W-1:0]   rdData
);

  localparam int GAP_W = WORD_W - 2 - SAMPLE_W;

  logic [SAMPLE_W-1:0] sampleReg;
  logic [SAMPLE_W-1:0] sampleOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull   <= 1'b0;
      sampleReg <= '0;
    end else if (strobe.load) begin
      bufFull   <= 1'b1;
      sampleReg <= entData;
    end else if (strobe.consume) begin
      bufFull   <= 1'b0;
    end
  end

  assign sampleOut = (status == ST_READY) ? sampleReg : '0;
  assign rdData    = {status, {GAP_W{1'b0}}, sampleOut};

endmodule

// File: rtl/seed_csr_unit.sv
module seed_csr_unit
  import seed_csr_pkg::*;
#(
  parameter int BIST_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic [2:0]  funct3,
  input  logic [11:0] csrAddr,
  input  logic [4:0]  rs1Idx,
  input  logic [31:0] rs1Data,
  input  logic        entValid,
  input  logic [15:0] entData,
  output logic        entReady,
  input  logic        faultIn,
  output logic        hit,
  output logic        illegal,
  output logic        rdWe,
  output logic [31:0] rdData
);

  seedStatus_e status;
  seedStrobe_t strobe;
  logic        bufFull;

  seed_csr_ctrl #(.BIST_CYCLES(BIST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .funct3(funct3),
    .csrAddr(csrAddr), .rs1Idx(rs1Idx), .bufFull(bufFull),
    .entValid(entValid), .faultIn(faultIn), .entReady(entReady),
    .hit(hit), .illegal(illegal), .rdWe(rdWe), .status(status),
    .strobe(strobe)
  );

  seed_csr_dp #(.SAMPLE_W(16), .WORD_W(32)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .entData(entData), .bufFull(bufFull), .rdData(rdData)
  );

endmodule

// File: rtl/seed_csr_chk.sv
module seed_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic [2:0]  funct3,
  input logic [11:0] csrAddr,
  input logic [4:0]  rs1Idx,
  input logic [31:0] rs1Data,
  input logic        entReady,
  input logic        illegal,
  input logic        rdWe,
  input logic [31:0] rdData,
  input logic        bufFull
);

  // R1
  off_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && csrAddr != 12'h015) |-> (!rdWe && !illegal));

  // R3
  rs_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && csrAddr == 12'h015 && funct3 inside {3'b010, 3'b011} && rs1Idx == 5'd0)
      |-> (illegal && !rdWe));

  // R5
  zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && csrAddr == 12'h015 && funct3 == 3'b010 && rs1Idx != 5'd0 && rs1Data == 32'd0)
      |-> (rdWe && !illegal));

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (illegal && bufFull) |=> bufFull);

  // R9
  consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdWe && rdData[31:30] == 2'b10) |=> !bufFull);

  // R12
  dead_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[31:30] == 2'b11) |=> (rdData[31:30] == 2'b11 && !entReady));

  // R11
  bist_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[31:30] == 2'b00) |-> !entReady);

endmodule

bind seed_csr_unit seed_csr_chk uChk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .funct3(funct3),
  .csrAddr(csrAddr), .rs1Idx(rs1Idx), .rs1Data(rs1Data),
  .entReady(entReady), .illegal(illegal), .rdWe(rdWe),
  .rdData(rdData), .bufFull(bufFull)
);

// File: tb/tb_seed_csr_unit.sv
module tb_seed_csr_unit;

  localparam int CLK_PERIOD = 10;
  localparam int BIST_N     = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [2:0]  funct3 = '0;
  logic [11:0] csrAddr = '0;
  logic [4:0]  rs1Idx = '0;
  logic [31:0] rs1Data = '0;
  logic        entValid = 1'b0;
  logic [15:0] entData = '0;
  logic        faultIn = 1'b0;
  logic        entReady, hit, illegal, rdWe;
  logic [31:0] rdData;

  seed_csr_unit #(.BIST_CYCLES(BIST_N)) dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .funct3(funct3),
    .csrAddr(csrAddr), .rs1Idx(rs1Idx), .rs1Data(rs1Data),
    .entValid(entValid), .entData(entData), .entReady(entReady),
    .faultIn(faultIn), .hit(hit), .illegal(illegal), .rdWe(rdWe),
    .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        expIll;
    logic        expWe;
    logic [31:0] expWord;
    string       req;
  } expItem_t;

  expItem_t scoreQ[$];
  int nChecks = 0;
  int nFails  = 0;
  event sampleEv;

  localparam logic [31:0] W_BIST = 32'h0000_0000;
  localparam logic [31:0] W_WAIT = 32'h4000_0000;
  localparam logic [31:0] W_DEAD = 32'hC000_0000;

  task automatic checkBit(input logic act, input logic exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // monitor: pop expected item and compare against live outputs
  initial begin
    forever begin
      @(sampleEv);
      if (scoreQ.size() != 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        nChecks++;
        if (illegal !== it.expIll || rdWe !== it.expWe ||
            (it.expWe && rdData !== it.expWord)) begin
          nFails++;
          $display("FAIL %s: actual ill=%b we=%b word=%h expected ill=%b we=%b word=%h",
                   it.req, illegal, rdWe, rdData, it.expIll, it.expWe, it.expWord);
        end
      end
    end
  end

  // driver: one-cycle access, expected item pushed to the scoreboard
  task automatic access(input logic [2:0] f3, input logic [11:0] addr,
                        input logic [4:0] idx, input logic [31:0] data,
                        input logic eIll, input logic eWe,
                        input logic [31:0] eWord, input string req);
    expItem_t it;
    @(negedge clk);
    accValid = 1'b1; funct3 = f3; csrAddr = addr; rs1Idx = idx; rs1Data = data;
    it.expIll = eIll; it.expWe = eWe; it.expWord = eWord; it.req = req;
    scoreQ.push_back(it);
    #(CLK_PERIOD/4);
    ->sampleEv;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic loadSample(input logic [15:0] s);
    @(negedge clk);
    entValid = 1'b1; entData = s;
    @(negedge clk);
    entValid = 1'b0;
  endtask

  function automatic logic [31:0] readyWord(input logic [15:0] s);
    return {2'b10, 14'd0, s};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkBit(entReady, 1'b0, "R11 reset entReady");
    checkBit(rdWe, 1'b0, "R10 reset rdWe");
    rstN = 1'b1;
    checkBit(entReady, 1'b0, "R11 self-test entReady");
    // self-test status, swap form with zero operand legal (R2, R8, R11)
    access(3'b001, 12'h015, 5'd0, 32'h0, 1'b0, 1'b1, W_BIST, "R11 self-test word");
    access(3'b010, 12'h015, 5'd0, 32'h0, 1'b1, 1'b0, 32'h0, "R3 during self-test");
    repeat (BIST_N + 2) @(negedge clk);
    checkBit(entReady, 1'b1, "R11 ready after self-test");
    access(3'b101, 12'h015, 5'd0, 32'h0, 1'b0, 1'b1, W_WAIT, "R2 CSRRWI imm0 wait");

    loadSample(16'hA5C3);
    checkBit(entReady, 1'b0, "R11 full buffer");
    // illegal and ignored accesses must not consume (R10, R1, R7)
    access(3'b010, 12'h015, 5'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0, "R3 CSRRS x0");
    access(3'b011, 12'h015, 5'd0, 32'h1234_5678, 1'b1, 1'b0, 32'h0, "R3 CSRRC x0");
    access(3'b110, 12'h015, 5'd0, 32'h0, 1'b1, 1'b0, 32'h0, "R4 CSRRSI 0");
    access(3'b111, 12'h015, 5'd0, 32'h0, 1'b1, 1'b0, 32'h0, "R4 CSRRCI 0");
    access(3'b010, 12'h300, 5'd5, 32'h0, 1'b0, 1'b0, 32'h0, "R1 other address");
    access(3'b001, 12'h016, 5'd0, 32'h0, 1'b0, 1'b0, 32'h0, "R1 neighbour address");
    access(3'b000, 12'h015, 5'd5, 32'h0, 1'b0, 1'b0, 32'h0, "R7 funct3 000");
    access(3'b100, 12'h015, 5'd5, 32'h0, 1'b0, 1'b0, 32'h0, "R7 funct3 100");
    // nonzero index with zero data is a writing access
    access(3'b010, 12'h015, 5'd5, 32'h0, 1'b0, 1'b1, readyWord(16'hA5C3), "R5 R10 CSRRS x5=0");
    access(3'b011, 12'h015, 5'd3, 32'hDEAD_BEEF, 1'b0, 1'b1, W_WAIT, "R9 wait after consume");

    loadSample(16'h1234);
    access(3'b110, 12'h015, 5'd7, 32'hFFFF_FFFF, 1'b0, 1'b1, readyWord(16'h1234), "R5 R6 CSRRSI 7");
    loadSample(16'hBEEF);
    access(3'b111, 12'h015, 5'd1, 32'h0000_FFFF, 1'b0, 1'b1, readyWord(16'hBEEF), "R5 R6 CSRRCI 1");
    loadSample(16'h0F0F);
    access(3'b101, 12'h015, 5'd31, 32'h0, 1'b0, 1'b1, readyWord(16'h0F0F), "R2 CSRRWI 31");
    access(3'b001, 12'h015, 5'd9, 32'hAAAA_5555, 1'b0, 1'b1, W_WAIT, "R9 R2 CSRRW wait");

    loadSample(16'h5555);
    @(negedge clk); faultIn = 1'b1;
    @(negedge clk); faultIn = 1'b0;
    access(3'b001, 12'h015, 5'd0, 32'h0, 1'b0, 1'b1, W_DEAD, "R12 dead");
    repeat (3) @(negedge clk);
    checkBit(entReady, 1'b0, "R12 entReady dead");
    access(3'b010, 12'h015, 5'd2, 32'h0, 1'b0, 1'b1, W_DEAD, "R12 dead sticky R8");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule